// File: doc/BRIEF.md
# Dual-Action Opcode Execute Unit

This unit is the execute stage of an 8-bit accumulator processor for opcodes whose two lowest bits are both set. In such an opcode the memory-modify action and the accumulator action of the same opcode row both take place. The byte produced by the modify step (shifted, rotated, decremented or incremented) goes back to memory. The same byte is also the operand of the accumulator operation that follows.

On each cycle the caller may raise `issue` with an opcode, the fetched operand and the current A, X and flag values. One clock later the unit returns the following, with `valid` high:
- the new A and X;
- the write-back byte and its write enable;
- the new flags;
- the operand length in bytes that the addressing column of the opcode implies.

The unit also decodes the skip-operand opcodes and the lock-up opcodes that share the opcode map. A lock-up opcode sets a sticky halt latch, and only reset clears it.

Top module: `combo_exec_unit`

## Requirements
- R1: While reset is low and after reset, `valid`, `mem_we` and `halted` are 0, and `acc_out`, `x_out`, `mem_wdata`, `flags_out` and `op_len` are all zero.
- R2: The result of an accepted opcode appears on the outputs one clock after `issue`, with `valid` set to 1. On a cycle without `issue`, `valid` and `mem_we` drop to 0 and the data outputs hold. The flag ports are ordered {N,V,Z,C} from bit 3 down to bit 0.
- R3: For opcodes with bits 1:0 = 11, bits 4:2 != 010 and bits 7:5 of 000, 001 or 010, the operand is shifted left, rotated left through C, or shifted right. The shifted byte is written to memory and C takes the bit shifted out. A then becomes A OR, A AND, or A XOR the shifted byte. N and Z follow the new A, and V is unchanged.
- R4: For bits 7:5 = 011 (bits 4:2 != 010), the operand is rotated right through C and written to memory. A then becomes A + rotated byte + the carry produced by the rotate, in binary. C takes the carry out, V the signed overflow, and N and Z follow A.
- R5: For bits 7:5 = 100 (bits 4:2 != 010), memory receives A AND X. A, X and the flags are unchanged.
- R6: For bits 7:5 = 101 (every column), the operand is loaded into both A and X, N and Z follow it, and nothing is written.
- R7: For bits 7:5 = 110 (bits 4:2 != 010), memory receives operand - 1. A is compared with that byte: C = (A >= byte), and N and Z follow A - byte. A and V are unchanged.
- R8: For bits 7:5 = 111 (bits 4:2 != 010), memory receives operand + 1, and A becomes A - byte - (1 - C). Opcode 0xEB computes A - operand - (1 - C) with no write. In both cases C = no borrow, V = signed overflow, and N and Z follow A.
- R9: 0x0B and 0x2B set A = A AND operand with C = bit 7 of A. 0x4B ANDs, then shifts A right, with C = the bit shifted out. 0x6B ANDs, then rotates A right through C, with C = the bit shifted out. N and Z follow A.
- R10: 0x8B sets A = X AND operand. 0xCB sets X = (A AND X) - operand with C = ((A AND X) >= operand). N and Z follow the changed register.
- R11: Opcodes 0x02, 0x12, 0x22, 0x32, 0x42, 0x52, 0x62, 0x72, 0x92, 0xB2, 0xD2 and 0xF2 set `halted` one clock after issue, with `op_len` = 1. While `halted` is 1, every `issue` is ignored (`valid` 0, `mem_we` 0, outputs held) until reset.
- R12: The skip opcodes change no register, flag or memory: 0x04, 0x44, 0x64, 0x0C, 0x14, 0x34, 0x54, 0x74, 0xD4, 0xF4, 0x1A, 0x3A, 0x5A, 0x7A, 0xDA, 0xFA, 0x1C, 0x3C, 0x5C, 0x7C, 0xDC, 0xFC, 0x80, 0x82, 0x89, 0xC2 and 0xE2. Every other opcode outside this unit's groups passes A, X and the flags through with `op_len` = 0.
- R13: `op_len` is set by bits 4:2. The values 011 and 111 give 3. The value 110 gives 3 when bits 1:0 = 11 and 1 for skip opcodes. All other values give 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the only way to clear the halt latch |
| issue | input | 1 | Opcode and operands are presented this cycle |
| opcode | input | 8 | Opcode byte |
| operand | input | 8 | Fetched memory or immediate byte |
| acc_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current X register |
| flags_in | input | 4 | Current flags {N,V,Z,C} |
| valid | output | 1 | Result of an accepted opcode is present |
| acc_out | output | 8 | New accumulator |
| x_out | output | 8 | New X register |
| mem_wdata | output | 8 | Memory write-back byte |
| mem_we | output | 1 | Memory write-back enable |
| flags_out | output | 4 | New flags {N,V,Z,C} |
| op_len | output | 2 | Instruction length in bytes (0 when not decoded here) |
| halted | output | 1 | Sticky halt latch |

## Verification
The hardest condition to bring about is the locked state followed by a stream of opcodes that would each do work if accepted. The bench issues a lock-up opcode and then drives 100 pseudo-random opcodes, operands and register values. It checks that nothing moves, and then that reset alone unlocks the unit. The second subtle case is the rotate-then-add row. Here the carry entering the addition comes from the rotate, not from the incoming flag. The stimulus covers both carry-in values with operands whose low and high bits differ, so a design that mixes up the two carries gives a different sum.

// File: rtl/combo_pkg.sv
package combo_pkg;

    localparam int OPW = 8;

    typedef enum logic [3:0] {
        K_NONE, K_SKIP, K_HALT, K_PAIR, K_ANC, K_ALR,
        K_ARR, K_XAND, K_LDAX, K_SBX, K_SBC
    } kind_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    function automatic logic [1:0] col_len(input logic [2:0] col, input logic implied_col);
        case (col)
            3'b011, 3'b111: return 2'd3;
            3'b110:         return implied_col ? 2'd1 : 2'd3;
            default:        return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/combo_decode.sv
module combo_decode
    import combo_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    output kind_e          kind,
    output logic [1:0]     len,
    output logic [2:0]     row
);

    logic [2:0] col;
    assign col = opcode[4:2];
    assign row = opcode[7:5];

    always_comb begin
        kind = K_NONE;
        len  = 2'd0;
        if (opcode[1:0] == 2'b11) begin
            len = col_len(col, 1'b0);
            if (row == 3'b101) begin
                kind = K_LDAX;
            end else if (col == 3'b010) begin
                case (row)
                    3'b000, 3'b001: kind = K_ANC;
                    3'b010:         kind = K_ALR;
                    3'b011:         kind = K_ARR;
                    3'b100:         kind = K_XAND;
                    3'b110:         kind = K_SBX;
                    default:        kind = K_SBC;
                endcase
            end else begin
                kind = K_PAIR;
            end
        end else begin
            case (opcode)
                8'h02, 8'h12, 8'h22, 8'h32, 8'h42, 8'h52,
                8'h62, 8'h72, 8'h92, 8'hB2, 8'hD2, 8'hF2: begin
                    kind = K_HALT;
                    len  = 2'd1;
                end
                8'h04, 8'h44, 8'h64, 8'h0C, 8'h14, 8'h34, 8'h54,
                8'h74, 8'hD4, 8'hF4, 8'h1A, 8'h3A, 8'h5A, 8'h7A,
                8'hDA, 8'hFA, 8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'hDC,
                8'hFC, 8'h80, 8'h82, 8'h89, 8'hC2, 8'hE2: begin
                    kind = K_SKIP;
                    len  = col_len(col, 1'b1);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/combo_rmw.sv
module combo_rmw #(
    parameter int DW = 8
) (
    input  logic [2:0]    row,
    input  logic [DW-1:0] din,
    input  logic          cin,
    output logic [DW-1:0] dout,
    output logic          cout
);

    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        dout = din;
        cout = cin;
        case (row)
            3'b000: {cout, dout} = {din, 1'b0};
            3'b001: {cout, dout} = {din, cin};
            3'b010: {dout, cout} = {1'b0, din};
            3'b011: {dout, cout} = {cin, din};
            3'b110: dout = din - ONE;
            3'b111: dout = din + ONE;
            default: ;
        endcase
    end

endmodule

// File: rtl/combo_addsub.sv
module combo_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          ovf
);

    logic [DW-1:0] b_eff;
    logic [DW:0]   total;

    assign b_eff = sub ? ~b : b;
    assign total = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
    assign sum   = total[DW-1:0];
    assign cout  = total[DW];
    assign ovf   = (a[DW-1] == b_eff[DW-1]) && (sum[DW-1] != a[DW-1]);

endmodule

// File: rtl/combo_exec_unit.sv
module combo_exec_unit
    import combo_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           issue,
    input  logic [OPW-1:0] opcode,
    input  logic [DW-1:0]  operand,
    input  logic [DW-1:0]  acc_in,
    input  logic [DW-1:0]  x_in,
    input  logic [3:0]     flags_in,
    output logic           valid,
    output logic [DW-1:0]  acc_out,
    output logic [DW-1:0]  x_out,
    output logic [DW-1:0]  mem_wdata,
    output logic           mem_we,
    output logic [3:0]     flags_out,
    output logic [1:0]     op_len,
    output logic           halted
);

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] xr;
        logic [DW-1:0] wdata;
        logic          we;
        flags_t        fl;
        logic [1:0]    len;
        logic          valid;
        logic          halted;
    } state_t;

    state_t st_d, st_q;

    kind_e         kind;
    logic [1:0]    dec_len;
    logic [2:0]    row;
    flags_t        fin;
    logic [DW-1:0] rmw_out;
    logic          rmw_cout;
    logic [DW-1:0] and_imm;
    logic [DW-1:0] ax_and;

    logic [DW-1:0] ar_b, ar_sum;
    logic          ar_cin, ar_sub, ar_cout, ar_ovf;
    logic [DW-1:0] cmp_a, cmp_b, cmp_sum;
    logic          cmp_cout, cmp_ovf;

    assign fin     = flags_t'(flags_in);
    assign and_imm = acc_in & operand;
    assign ax_and  = acc_in & x_in;

    combo_decode u_dec (
        .opcode (opcode),
        .kind   (kind),
        .len    (dec_len),
        .row    (row)
    );

    combo_rmw #(.DW(DW)) u_rmw (
        .row  (row),
        .din  (operand),
        .cin  (fin.c),
        .dout (rmw_out),
        .cout (rmw_cout)
    );

    // Accumulator adder: rotate-right-add, increment-subtract, immediate subtract
    assign ar_b   = (kind == K_SBC) ? operand : rmw_out;
    assign ar_sub = (kind == K_SBC) || (row == 3'b111);
    assign ar_cin = (kind == K_PAIR && row == 3'b011) ? rmw_cout : fin.c;

    combo_addsub #(.DW(DW)) u_arith (
        .a    (acc_in),
        .b    (ar_b),
        .cin  (ar_cin),
        .sub  (ar_sub),
        .sum  (ar_sum),
        .cout (ar_cout),
        .ovf  (ar_ovf)
    );

    // Comparator: decrement-compare and masked X subtract
    assign cmp_a = (kind == K_SBX) ? ax_and : acc_in;
    assign cmp_b = (kind == K_SBX) ? operand : rmw_out;

    combo_addsub #(.DW(DW)) u_cmp (
        .a    (cmp_a),
        .b    (cmp_b),
        .cin  (1'b1),
        .sub  (1'b1),
        .sum  (cmp_sum),
        .cout (cmp_cout),
        .ovf  (cmp_ovf)
    );

    function automatic logic [1:0] nz_of(input logic [DW-1:0] v);
        return {v[DW-1], v == '0};
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.we    = 1'b0;
        if (issue && !st_q.halted) begin
            st_d.valid = 1'b1;
            st_d.acc   = acc_in;
            st_d.xr    = x_in;
            st_d.fl    = fin;
            st_d.len   = dec_len;
            case (kind)
                K_HALT: st_d.halted = 1'b1;
                K_PAIR: begin
                    st_d.wdata = rmw_out;
                    st_d.we    = 1'b1;
                    case (row)
                        3'b000: begin
                            st_d.acc  = acc_in | rmw_out;
                            st_d.fl.c = rmw_cout;
                        end
                        3'b001: begin
                            st_d.acc  = acc_in & rmw_out;
                            st_d.fl.c = rmw_cout;
                        end
                        3'b010: begin
                            st_d.acc  = acc_in ^ rmw_out;
                            st_d.fl.c = rmw_cout;
                        end
                        3'b011, 3'b111: begin
                            st_d.acc  = ar_sum;
                            st_d.fl.c = ar_cout;
                            st_d.fl.v = ar_ovf;
                        end
                        3'b100: st_d.wdata = ax_and;
                        3'b110: begin
                            st_d.fl.c = cmp_cout;
                            {st_d.fl.n, st_d.fl.z} = nz_of(cmp_sum);
                        end
                        default: st_d.we = 1'b0;
                    endcase
                    if (row != 3'b100 && row != 3'b110)
                        {st_d.fl.n, st_d.fl.z} = nz_of(st_d.acc);
                end
                K_ANC: begin
                    st_d.acc  = and_imm;
                    st_d.fl.c = and_imm[DW-1];
                    {st_d.fl.n, st_d.fl.z} = nz_of(and_imm);
                end
                K_ALR: begin
                    st_d.acc  = {1'b0, and_imm[DW-1:1]};
                    st_d.fl.c = and_imm[0];
                    {st_d.fl.n, st_d.fl.z} = nz_of({1'b0, and_imm[DW-1:1]});
                end
                K_ARR: begin
                    st_d.acc  = {fin.c, and_imm[DW-1:1]};
                    st_d.fl.c = and_imm[0];
                    {st_d.fl.n, st_d.fl.z} = nz_of({fin.c, and_imm[DW-1:1]});
                end
                K_XAND: begin
                    st_d.acc = x_in & operand;
                    {st_d.fl.n, st_d.fl.z} = nz_of(x_in & operand);
                end
                K_LDAX: begin
                    st_d.acc = operand;
                    st_d.xr  = operand;
                    {st_d.fl.n, st_d.fl.z} = nz_of(operand);
                end
                K_SBX: begin
                    st_d.xr   = cmp_sum;
                    st_d.fl.c = cmp_cout;
                    {st_d.fl.n, st_d.fl.z} = nz_of(cmp_sum);
                end
                K_SBC: begin
                    st_d.acc  = ar_sum;
                    st_d.fl.c = ar_cout;
                    st_d.fl.v = ar_ovf;
                    {st_d.fl.n, st_d.fl.z} = nz_of(ar_sum);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid     = st_q.valid;
    assign acc_out   = st_q.acc;
    assign x_out     = st_q.xr;
    assign mem_wdata = st_q.wdata;
    assign mem_we    = st_q.we;
    assign flags_out = st_q.fl;
    assign op_len    = st_q.len;
    assign halted    = st_q.halted;

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R11
    halted_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (!valid && !mem_we));

    // R2
    we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> valid);

    // R5
    store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !halted && opcode[1:0] == 2'b11 && opcode[7:5] == 3'b100 && opcode[4:2] != 3'b010)
        |=> (mem_we && mem_wdata == $past(acc_in & x_in) && flags_out == $past(flags_in)));

    // R3
    v_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !halted && opcode[1:0] == 2'b11 && !opcode[7] && opcode[6:5] != 2'b11 && opcode[4:2] != 3'b010)
        |=> (flags_out[2] == $past(flags_in[2])));

    // R12
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !halted && kind == K_SKIP)
        |=> (!mem_we && acc_out == $past(acc_in) && x_out == $past(x_in) && flags_out == $past(flags_in)));

endmodule

// File: tb/combo_exec_unit_bench.sv
`timescale 1ns/1ps
module combo_exec_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue = 1'b0;
    logic [7:0] opcode = '0, operand = '0, acc_in = '0, x_in = '0;
    logic [3:0] flags_in = '0;
    logic       valid, mem_we, halted;
    logic [7:0] acc_out, x_out, mem_wdata;
    logic [3:0] flags_out;
    logic [1:0] op_len;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    combo_exec_unit u_combo_exec_unit (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .operand(operand),
        .acc_in(acc_in), .x_in(x_in), .flags_in(flags_in), .valid(valid),
        .acc_out(acc_out), .x_out(x_out), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .flags_out(flags_out), .op_len(op_len), .halted(halted)
    );

    typedef struct packed {
        logic [7:0] op, m, a, x;
        logic [3:0] fi;
        logic [7:0] ea, ex, ewd;
        logic       ewe;
        logic [3:0] ef;
        logic [1:0] el;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [0:NV-1] = '{
        '{8'h0F, 8'h81, 8'h01, 8'h00, 4'h0, 8'h03, 8'h00, 8'h02, 1'b1, 4'h1, 2'd3},
        '{8'h27, 8'h80, 8'hFF, 8'h00, 4'h1, 8'h01, 8'h00, 8'h01, 1'b1, 4'h1, 2'd2},
        '{8'h47, 8'h03, 8'h01, 8'h00, 4'h0, 8'h00, 8'h00, 8'h01, 1'b1, 4'h3, 2'd2},
        '{8'h67, 8'h02, 8'h7F, 8'h00, 4'h0, 8'h80, 8'h00, 8'h01, 1'b1, 4'hC, 2'd2},
        '{8'h77, 8'h01, 8'h10, 8'h00, 4'h1, 8'h91, 8'h00, 8'h80, 1'b1, 4'h8, 2'd2},
        '{8'h9F, 8'h55, 8'hF0, 8'h3C, 4'hA, 8'hF0, 8'h3C, 8'h30, 1'b1, 4'hA, 2'd3},
        '{8'hA7, 8'h00, 8'h22, 8'h33, 4'h5, 8'h00, 8'h00, 8'h00, 1'b0, 4'h7, 2'd2},
        '{8'hC7, 8'h06, 8'h05, 8'h00, 4'h0, 8'h05, 8'h00, 8'h05, 1'b1, 4'h3, 2'd2},
        '{8'hDB, 8'h00, 8'h05, 8'h00, 4'h4, 8'h05, 8'h00, 8'hFF, 1'b1, 4'h4, 2'd3},
        '{8'hE7, 8'h0F, 8'h10, 8'h00, 4'h1, 8'h00, 8'h00, 8'h10, 1'b1, 4'h3, 2'd2},
        '{8'hE3, 8'h00, 8'h80, 8'h00, 4'h1, 8'h7F, 8'h00, 8'h01, 1'b1, 4'h5, 2'd2},
        '{8'h0B, 8'h81, 8'hC3, 8'h00, 4'h0, 8'h81, 8'h00, 8'h00, 1'b0, 4'h9, 2'd2},
        '{8'h4B, 8'h03, 8'hFF, 8'h00, 4'h0, 8'h01, 8'h00, 8'h00, 1'b0, 4'h1, 2'd2},
        '{8'h6B, 8'h03, 8'hFF, 8'h00, 4'h1, 8'h81, 8'h00, 8'h00, 1'b0, 4'h9, 2'd2},
        '{8'h8B, 8'h3C, 8'hFF, 8'h0F, 4'h0, 8'h0C, 8'h0F, 8'h00, 1'b0, 4'h0, 2'd2},
        '{8'hCB, 8'h10, 8'hF0, 8'h3C, 4'h0, 8'hF0, 8'h20, 8'h00, 1'b0, 4'h1, 2'd2},
        '{8'hEB, 8'h01, 8'h00, 8'h00, 4'h1, 8'hFF, 8'h00, 8'h00, 1'b0, 4'h8, 2'd2},
        '{8'h1A, 8'h77, 8'h12, 8'h34, 4'h5, 8'h12, 8'h34, 8'h00, 1'b0, 4'h5, 2'd1},
        '{8'h0C, 8'h77, 8'h12, 8'h34, 4'hA, 8'h12, 8'h34, 8'h00, 1'b0, 4'hA, 2'd3},
        '{8'h80, 8'h77, 8'h12, 8'h34, 4'h0, 8'h12, 8'h34, 8'h00, 1'b0, 4'h0, 2'd2}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [7:0] op, input logic [7:0] m, input logic [7:0] a,
                         input logic [7:0] x, input logic [3:0] f);
        @(negedge clk);
        issue = 1'b1; opcode = op; operand = m; acc_in = a; x_in = x; flags_in = f;
        @(negedge clk);
        issue = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic string req_of(input logic [7:0] op);
        if (op[1:0] != 2'b11) return "R12";
        if (op[7:5] == 3'b101) return "R6";
        if (op[4:2] == 3'b010) begin
            case (op[7:5])
                3'b100, 3'b110: return "R10";
                3'b111:         return "R8";
                default:        return "R9";
            endcase
        end
        case (op[7:5])
            3'b011:  return "R4";
            3'b100:  return "R5";
            3'b110:  return "R7";
            3'b111:  return "R8";
            default: return "R3";
        endcase
    endfunction

    // Independent reference: signed/unsigned integer arithmetic, separate steps
    function automatic void add8(input logic [7:0] a, input logic [7:0] b, input logic ci,
                                 output logic [7:0] s, output logic co, output logic ov);
        int us, ss;
        us = int'(a) + int'(b) + int'(ci);
        ss = int'($signed(a)) + int'($signed(b)) + int'(ci);
        s  = us[7:0];
        co = us > 255;
        ov = (ss > 127) || (ss < -128);
    endfunction

    function automatic vec_t model(input logic [7:0] op, input logic [7:0] m, input logic [7:0] a,
                                   input logic [7:0] x, input logic [3:0] f);
        vec_t r;
        logic n, v, z, c, co, ov;
        logic [7:0] t, s;
        r = '0;
        r.op = op; r.m = m; r.a = a; r.x = x; r.fi = f;
        r.ea = a; r.ex = x; r.ef = f; r.ewe = 1'b0; r.ewd = 8'h00;
        r.el = (op[4:2] == 3'b011 || op[4:2] == 3'b111 || op[4:2] == 3'b110) ? 2'd3 : 2'd2;
        {n, v, z, c} = f;
        if (op[7:5] == 3'b101) begin
            r.ea = m; r.ex = m; n = m[7]; z = (m == 0);
        end else if (op[4:2] == 3'b010) begin
            case (op[7:5])
                3'b000, 3'b001: begin t = a & m; r.ea = t; c = t[7]; end
                3'b010: begin t = a & m; r.ea = t >> 1; c = t[0]; end
                3'b011: begin t = a & m; r.ea = {c, t[7:1]}; c = t[0]; end
                3'b100: r.ea = x & m;
                3'b110: begin t = a & x; r.ex = t - m; c = (t >= m); n = r.ex[7]; z = (r.ex == 0); end
                default: begin add8(a, ~m, c, s, co, ov); r.ea = s; c = co; v = ov; end
            endcase
            if (op[7:5] != 3'b110) begin n = r.ea[7]; z = (r.ea == 0); end
        end else begin
            r.ewe = 1'b1;
            case (op[7:5])
                3'b000: begin t = m << 1; c = m[7]; r.ea = a | t; end
                3'b001: begin t = {m[6:0], c}; c = m[7]; r.ea = a & t; end
                3'b010: begin t = m >> 1; c = m[0]; r.ea = a ^ t; end
                3'b011: begin t = {c, m[7:1]}; add8(a, t, m[0], s, co, ov); r.ea = s; c = co; v = ov; end
                3'b100: t = a & x;
                3'b110: begin t = m - 8'd1; c = (a >= t); s = a - t; n = s[7]; z = (s == 0); end
                default: begin t = m + 8'd1; add8(a, ~t, c, s, co, ov); r.ea = s; c = co; v = ov; end
            endcase
            r.ewd = t;
            if (op[7:5] != 3'b100 && op[7:5] != 3'b110) begin n = r.ea[7]; z = (r.ea == 0); end
        end
        r.ef = {n, v, z, c};
        return r;
    endfunction

    task automatic compare(input vec_t e);
        string rq;
        rq = req_of(e.op);
        check("R2", "valid", valid, 1);
        check(rq, $sformatf("acc op=%02h", e.op), acc_out, e.ea);
        check(rq, $sformatf("x op=%02h", e.op), x_out, e.ex);
        check(rq, $sformatf("flags op=%02h", e.op), flags_out, e.ef);
        check(rq, $sformatf("we op=%02h", e.op), mem_we, e.ewe);
        if (e.ewe) check(rq, $sformatf("wdata op=%02h", e.op), mem_wdata, e.ewd);
        check("R13", $sformatf("len op=%02h", e.op), op_len, e.el);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lf;
        logic [7:0]  held_a;
        logic [7:0]  halts [0:11];
        halts = '{8'h02, 8'h12, 8'h22, 8'h32, 8'h42, 8'h52, 8'h62, 8'h72, 8'h92, 8'hB2, 8'hD2, 8'hF2};
        lf = 16'hACE1;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid", valid, 0);
        check("R1", "we", mem_we, 0);
        check("R1", "halted", halted, 0);
        check("R1", "acc/x/wdata", {acc_out, x_out, mem_wdata}, 0);
        check("R1", "flags/len", {flags_out, op_len}, 0);

        // Table of directed vectors
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i].op, VEC[i].m, VEC[i].a, VEC[i].x, VEC[i].fi);
            compare(VEC[i]);
        end

        // R2 idle cycle: valid and we drop, data holds
        do_op(8'h07, 8'h40, 8'h01, 8'h00, 4'h0);
        @(negedge clk);
        check("R2", "idle valid", valid, 0);
        check("R2", "idle we", mem_we, 0);
        check("R2", "idle acc held", acc_out, 8'h81);

        // R12 opcode outside every group passes through with length 0
        do_op(8'hA9, 8'h55, 8'h66, 8'h77, 4'h6);
        check("R12", "none acc", acc_out, 8'h66);
        check("R12", "none x", x_out, 8'h77);
        check("R12", "none flags", flags_out, 4'h6);
        check("R12", "none we", mem_we, 0);
        check("R13", "none len", op_len, 0);

        // Reference sweep of every combined opcode
        for (int i = 0; i < 64; i++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] op, m, a, x;
                logic [3:0] f;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                m = lf[7:0]; a = lf[15:8];
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                x = lf[7:0]; f = lf[11:8];
                if (k == 0) f[0] = 1'b0;
                if (k == 1) f[0] = 1'b1;
                op = {i[5:0], 2'b11};
                do_op(op, m, a, x, f);
                compare(model(op, m, a, x, f));
            end
        end

        // R11 every lock-up opcode
        for (int h = 0; h < 12; h++) begin
            do_reset();
            do_op(halts[h], 8'h00, 8'h11, 8'h22, 4'h0);
            check("R11", $sformatf("halt op=%02h", halts[h]), halted, 1);
            check("R11", "halt len", op_len, 1);
        end
        do_reset();
        do_op(8'h82, 8'h00, 8'h11, 8'h22, 4'h0);
        check("R11", "0x82 does not halt", halted, 0);

        // R11 latch holds across 100 random opcodes
        do_reset();
        do_op(8'h5A, 8'h00, 8'h3D, 8'h00, 4'h0);
        do_op(8'h02, 8'h00, 8'h3D, 8'h00, 4'h0);
        held_a = acc_out;
        check("R11", "halted set", halted, 1);
        for (int j = 0; j < 100; j++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_op(lf[7:0], lf[15:8], lf[15:8] ^ 8'h5A, lf[7:0] ^ 8'hC3, lf[3:0]);
            check("R11", "ignored valid", valid, 0);
            check("R11", "ignored we", mem_we, 0);
            check("R11", "still halted", halted, 1);
            check("R11", "acc held", acc_out, held_a);
        end
        do_reset();
        @(negedge clk);
        check("R11", "reset clears halt", halted, 0);
        do_op(8'hA7, 8'h80, 8'h00, 8'h00, 4'h0);
        check("R6", "works after reset", {acc_out, x_out}, 16'h8080);
        check("R6", "flags after reset", flags_out, 4'h8);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule